// File: doc/BRIEF.md
# Booth Multiply-Accumulate Unit

This block multiplies two 32-bit two's complement operands and adds a 64-bit running accumulate value in one pass through a single reduction tree. The operands are captured into registers under an enable. The multiplier is recoded into radix-4 Booth digits. The resulting partial-product rows, one row of negation correction bits and the accumulate register are all fed as rows of the same 4:2 compressor tree. The tree produces a redundant sum/carry pair, and one carry-propagate adder resolves that pair. Every result wraps modulo 2^64.

A mode input chooses the timing. In single-cycle mode the tree feeds the final adder directly. In two-cycle mode a sum/carry register pair sits between the tree and the adder. The adder's output is registered as the result and is also what the accumulate register loads when its load enable is high. A clear input empties the accumulate register. The reset is asserted asynchronously (active low) and released through a two-stage synchronizer, so the block stays idle for two clock edges after release.

Top module: `booth_mac`

## Requirements
- R1: While rst_n is low, and for two rising edges after it rises, result and acc_out read zero and every internal register holds zero.
- R2: a_in and b_in are captured into the operand registers at a rising edge where op_en is 1. With op_en at 0 the operand registers hold their value, and later results use the held operands.
- R3: With pipe_mode at 0, result at a rising edge equals A*B + ACC (signed, modulo 2^64). A and B are the operand register contents and ACC is the accumulate register content during the preceding cycle.
- R4: With pipe_mode at 1, a rising edge stores the tree's value of A*B + ACC into the sum/carry register pair, and result at that edge equals the sum of the pair as it stood before the edge. A product therefore reaches result two edges after its operands are captured.
- R5: At an edge with acc_ld at 1 and acc_clr at 0, the accumulate register takes the same value that result takes at that edge.
- R6: At an edge with acc_clr at 1, the accumulate register becomes zero, whatever acc_ld is.
- R7: At an edge with acc_clr and acc_ld both 0, the accumulate register keeps its value.
- R8: Extreme operands -2^31 and 2^31-1, in every pairing, and accumulation chains that overflow 64 bits give the exact result modulo 2^64.
- R9: Multiplier bit patterns that exercise all eight 3-bit Booth group codes (digits -2 to +2, including the 111 group that gives a negated zero row) give correct results.
- R10: The sum/carry register pair only loads while pipe_mode is 1. After a switch from 0 to 1, the first result is the sum of whatever the pair last held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_mode | input | 1 | 0: single-cycle path, 1: two-cycle path through the sum/carry registers |
| op_en | input | 1 | Capture a_in and b_in into the operand registers |
| a_in | input | 32 | Multiplicand, two's complement |
| b_in | input | 32 | Multiplier, two's complement |
| acc_clr | input | 1 | Zero the accumulate register (wins over acc_ld) |
| acc_ld | input | 1 | Load the final adder output into the accumulate register |
| result | output | 64 | Registered final adder output |
| acc_out | output | 64 | Accumulate register content |

## Verification
In single-cycle mode a product is due at result one edge after op_en captures its operands. In two-cycle mode it is due two edges after capture. The accumulate register changes at the same edge as result. The reference model keeps its own operand, accumulate, intermediate and result state and updates it on the same rising edges the design uses, including the two idle edges after reset release. Both outputs are sampled on the falling edge, while inputs are steady and the design's registers have settled, and compared with the model in every cycle. The model therefore tracks every edge of each latency instead of waiting a fixed delay, and this also covers the cycles around a mode switch.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  // Radix-4 Booth digit controls: negate, select 1x, select 2x
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  // Recode the overlapping group {b[2i+1], b[2i], b[2i-1]}
  function automatic booth_sel_t booth_recode(input logic [2:0] grp);
    booth_sel_t s;
    s.neg = grp[2];
    s.one = grp[1] ^ grp[0];
    s.two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
    return s;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int OP_W  = 32,
  parameter int RES_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]                  mcand,
  input  logic [OP_W-1:0]                  mplier,
  output logic [OP_W/2-1:0][RES_W-1:0]     rows_o,
  output logic [RES_W-1:0]                 corr_o
);
  import booth_mac_pkg::*;

  localparam int NUM_DIG = OP_W / 2;

  logic [OP_W:0]        mplier_x;
  logic [RES_W-1:0]     mult_1x;
  logic [RES_W-1:0]     mult_2x;
  logic [NUM_DIG-1:0]   neg_v;

  assign mplier_x = {mplier, 1'b0};
  assign mult_1x  = {{(RES_W-OP_W){mcand[OP_W-1]}}, mcand};
  assign mult_2x  = mult_1x << 1;

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_digit
    booth_sel_t       sel;
    logic [RES_W-1:0] mag;
    logic [RES_W-1:0] signed_mag;

    assign sel        = booth_recode(mplier_x[2*d+2 -: 3]);
    assign mag        = sel.one ? mult_1x : (sel.two ? mult_2x : '0);
    assign signed_mag = sel.neg ? ~mag : mag;
    assign rows_o[d]  = signed_mag << (2 * d);
    assign neg_v[d]   = sel.neg;
  end

  // The +1 of each negated row, placed at the row's lowest weight
  always_comb begin
    corr_o = '0;
    for (int d = 0; d < NUM_DIG; d++) begin
      corr_o[2*d] = neg_v[d];
    end
  end

endmodule

// File: rtl/csa42.sv
module csa42 #(
  parameter int W = 64
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] s1;
  logic [W-1:0] c1;
  logic [W-1:0] cin;
  logic [W-1:0] c2;

  // First full-adder layer; its carries move one column up
  assign s1  = x0 ^ x1 ^ x2;
  assign c1  = (x0 & x1) | (x0 & x2) | (x1 & x2);
  assign cin = {c1[W-2:0], 1'b0};

  // Second full-adder layer
  assign s_o = s1 ^ x3 ^ cin;
  assign c2  = (s1 & x3) | (s1 & cin) | (x3 & cin);
  assign c_o = {c2[W-2:0], 1'b0};

endmodule

// File: rtl/compress_tree.sv
module compress_tree #(
  parameter int W      = 64,
  parameter int LEVELS = 4,
  parameter int ROWS   = 2 << LEVELS
) (
  input  logic [ROWS-1:0][W-1:0] rows_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int NODES = 2 * ROWS - 2;

  // All levels stored back to back: level l starts at 2*ROWS - 2*(ROWS>>l)
  logic [NODES-1:0][W-1:0] node;

  assign node[ROWS-1:0] = rows_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int NIN     = ROWS >> l;
    localparam int IN_OFF  = 2 * ROWS - 2 * (ROWS >> l);
    localparam int OUT_OFF = 2 * ROWS - 2 * (ROWS >> (l + 1));
    for (genvar k = 0; k < NIN / 4; k++) begin : g_cell
      csa42 #(.W(W)) u_csa (
        .x0  (node[IN_OFF + 4*k]),
        .x1  (node[IN_OFF + 4*k + 1]),
        .x2  (node[IN_OFF + 4*k + 2]),
        .x3  (node[IN_OFF + 4*k + 3]),
        .s_o (node[OUT_OFF + 2*k]),
        .c_o (node[OUT_OFF + 2*k + 1])
      );
    end
  end

  assign sum_o   = node[NODES-2];
  assign carry_o = node[NODES-1];

endmodule

// File: rtl/booth_mac.sv
module booth_mac #(
  parameter int OP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pipe_mode,
  input  logic                op_en,
  input  logic [OP_W-1:0]     a_in,
  input  logic [OP_W-1:0]     b_in,
  input  logic                acc_clr,
  input  logic                acc_ld,
  output logic [2*OP_W-1:0]   result,
  output logic [2*OP_W-1:0]   acc_out
);
  localparam int RES_W    = 2 * OP_W;
  localparam int NUM_DIG  = OP_W / 2;
  localparam int RAW_ROWS = NUM_DIG + 2;
  localparam int LEVELS   = $clog2(RAW_ROWS) - 1;
  localparam int ROWS     = 2 << LEVELS;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  // State
  logic [OP_W-1:0]  a_q, b_q;
  logic [RES_W-1:0] acc_q, mid_s, mid_c, res_q;
  // Next state
  logic [OP_W-1:0]  a_d, b_d;
  logic [RES_W-1:0] acc_d, mid_s_d, mid_c_d;

  // Partial products and tree
  logic [NUM_DIG-1:0][RES_W-1:0] pp_rows;
  logic [RES_W-1:0]              corr_row;
  logic [ROWS-1:0][RES_W-1:0]    tree_rows;
  logic [RES_W-1:0]              tree_s, tree_c;
  logic [RES_W-1:0]              fa_x, fa_y, fin;

  booth_pp_gen #(.OP_W(OP_W), .RES_W(RES_W)) u_pp (
    .mcand  (a_q),
    .mplier (b_q),
    .rows_o (pp_rows),
    .corr_o (corr_row)
  );

  assign tree_rows[NUM_DIG-1:0] = pp_rows;
  assign tree_rows[NUM_DIG]     = corr_row;
  assign tree_rows[NUM_DIG+1]   = acc_q;   // accumulate folded in as a tree row

  if (ROWS > RAW_ROWS) begin : g_pad
    assign tree_rows[ROWS-1:RAW_ROWS] = '0;
  end

  compress_tree #(.W(RES_W), .LEVELS(LEVELS), .ROWS(ROWS)) u_tree (
    .rows_i  (tree_rows),
    .sum_o   (tree_s),
    .carry_o (tree_c)
  );

  // Final carry-propagate adder, fed from the tree or the mid registers
  assign fa_x = pipe_mode ? mid_s : tree_s;
  assign fa_y = pipe_mode ? mid_c : tree_c;
  assign fin  = fa_x + fa_y;

  always_comb begin
    a_d     = op_en ? a_in : a_q;
    b_d     = op_en ? b_in : b_q;
    mid_s_d = pipe_mode ? tree_s : mid_s;
    mid_c_d = pipe_mode ? tree_c : mid_c;
    if (acc_clr) begin
      acc_d = '0;
    end else if (acc_ld) begin
      acc_d = fin;
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      mid_s <= '0;
      mid_c <= '0;
      res_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      acc_q <= acc_d;
      mid_s <= mid_s_d;
      mid_c <= mid_c_d;
      res_q <= fin;
    end
  end

  assign result  = res_q;
  assign acc_out = acc_q;

endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
  parameter int OP_W  = 32,
  parameter int RES_W = 2 * OP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             acc_clr,
  input logic             acc_ld,
  input logic [OP_W-1:0]  a_q,
  input logic [OP_W-1:0]  b_q,
  input logic [RES_W-1:0] acc_q,
  input logic [RES_W-1:0] mid_s,
  input logic [RES_W-1:0] mid_c,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] acc_out
);

  // R3
  single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode |=> result == (RES_W'($signed($past(a_q))) * RES_W'($signed($past(b_q)))
                              + $past(acc_q)));

  // R4
  mid_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode |=> (mid_s + mid_c) == (RES_W'($signed($past(a_q))) * RES_W'($signed($past(b_q)))
                                      + $past(acc_q)));

  // R4
  pipe_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_mode |=> result == ($past(mid_s) + $past(mid_c)));

  // R10
  mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_mode |=> ($stable(mid_s) && $stable(mid_c)));

  // R5
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ld && !acc_clr) |=> acc_out == result);

  // R6
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> acc_out == '0);

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !acc_ld) |=> $stable(acc_out));

endmodule

bind booth_mac booth_mac_chk #(.OP_W(OP_W), .RES_W(2*OP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .acc_clr   (acc_clr),
  .acc_ld    (acc_ld),
  .a_q       (a_q),
  .b_q       (b_q),
  .acc_q     (acc_q),
  .mid_s     (mid_s),
  .mid_c     (mid_c),
  .result    (result),
  .acc_out   (acc_out)
);

// File: tb/booth_mac_bench.sv
module booth_mac_bench;

  logic        clk;
  logic        rst_n;
  logic        pipe_mode;
  logic        op_en;
  logic [31:0] a_in;
  logic [31:0] b_in;
  logic        acc_clr;
  logic        acc_ld;
  logic [63:0] result;
  logic [63:0] acc_out;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  booth_mac u_booth_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .op_en     (op_en),
    .a_in      (a_in),
    .b_in      (b_in),
    .acc_clr   (acc_clr),
    .acc_ld    (acc_ld),
    .result    (result),
    .acc_out   (acc_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // Behavioural reference model, updated on the design's clock edges
  int     m_a, m_b;
  longint m_acc, m_mid, m_res;
  int     m_idle;

  always @(posedge clk or negedge rst_n) begin
    longint tree_v, fin_v;
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_acc = 0; m_mid = 0; m_res = 0; m_idle = 0;
    end else if (m_idle < 2) begin
      m_idle = m_idle + 1;          // synchronizer still holds the core in reset (R1)
    end else begin
      tree_v = longint'(m_a) * longint'(m_b) + m_acc;
      fin_v  = pipe_mode ? m_mid : tree_v;
      m_res  = fin_v;
      if (acc_clr)      m_acc = 0;
      else if (acc_ld)  m_acc = fin_v;
      if (pipe_mode)    m_mid = tree_v;
      if (op_en) begin
        m_a = int'(a_in);
        m_b = int'(b_in);
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (result !== 64'(m_res)) begin
        n_fails++;
        $display("FAIL %s result got %h expected %h", cur_req, result, 64'(m_res));
      end
      n_checks++;
      if (acc_out !== 64'(m_acc)) begin
        n_fails++;
        $display("FAIL %s acc_out got %h expected %h", cur_req, acc_out, 64'(m_acc));
      end
    end
  end

  task automatic step(input bit pm, input bit en, input logic [31:0] a, input logic [31:0] b,
                      input bit clr, input bit ld);
    @(negedge clk);
    #1;
    pipe_mode = pm; op_en = en; a_in = a; b_in = b; acc_clr = clr; acc_ld = ld;
  endtask

  task automatic idle(input bit pm, input int n);
    for (int i = 0; i < n; i++) step(pm, 0, 32'h0, 32'h0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

  initial begin
    logic [31:0] pats [8];
    pipe_mode = 0; op_en = 0; a_in = 0; b_in = 0; acc_clr = 0; acc_ld = 0;
    rst_n = 0;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1;
    idle(0, 4);

    // R3: single-cycle products, accumulator empty
    cur_req = "R3";
    step(0, 1, 32'd3, 32'd7, 0, 0);
    step(0, 1, 32'hFFFF_FFFB, 32'd9, 0, 0);
    step(0, 1, 32'd12345, 32'hFFFF_FF00, 0, 0);
    step(0, 0, 32'd0, 32'd0, 0, 0);

    // R2: operands held with op_en low, inputs wiggle
    cur_req = "R2";
    step(0, 0, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0);
    step(0, 0, 32'h0BAD_F00D, 32'h7777_0000, 0, 0);
    step(0, 1, 32'd100, 32'd200, 0, 0);
    step(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);

    // R5: accumulate chain in single-cycle mode
    cur_req = "R5";
    step(0, 1, 32'd1000, 32'd1000, 0, 1);
    step(0, 1, 32'hFFFF_FC18, 32'd3, 0, 1);
    step(0, 1, 32'd77, 32'hFFFF_FFF0, 0, 1);
    step(0, 0, 32'd0, 32'd0, 0, 1);

    // R7: hold
    cur_req = "R7";
    step(0, 1, 32'd5, 32'd5, 0, 0);
    step(0, 1, 32'd9, 32'd9, 0, 0);

    // R6: clear wins over load
    cur_req = "R6";
    step(0, 1, 32'd50, 32'd50, 1, 1);
    step(0, 0, 32'd0, 32'd0, 0, 0);
    step(0, 0, 32'd0, 32'd0, 1, 0);

    // R8: extreme operands and 64-bit wrap of the accumulator
    cur_req = "R8";
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 1);
    step(0, 1, 32'h7FFF_FFFF, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 1, 32'h8000_0000, 32'h8000_0000, 0, 1);
    step(0, 0, 32'd0, 32'd0, 1, 0);

    // R9: multiplier patterns hitting every Booth group code
    cur_req = "R9";
    pats = '{32'hAAAA_AAAA, 32'h5555_5555, 32'hFFFF_FFFF, 32'hFFFF_0000,
             32'h0000_FFFF, 32'hCCCC_3333, 32'h6DB6_DB6D, 32'h9249_2492};
    foreach (pats[i]) begin
      step(0, 1, 32'h8000_0000, pats[i], 0, 0);
      step(0, 1, 32'h7FFF_FFFF, pats[i], 0, 0);
      step(0, 1, 32'hFEDC_BA98, pats[i], 0, 0);
    end

    // R4: two-cycle pipeline
    cur_req = "R4";
    step(1, 1, 32'd6, 32'd7, 0, 0);
    step(1, 1, 32'hFFFF_FFFE, 32'd11, 0, 0);
    step(1, 1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
    idle(1, 3);
    step(1, 1, 32'd40, 32'd40, 0, 1);
    step(1, 0, 32'd0, 32'd0, 0, 0);
    step(1, 1, 32'd3, 32'd3, 0, 1);
    idle(1, 2);

    // R10: mode switches with stale intermediate state
    cur_req = "R10";
    step(0, 1, 32'd999, 32'd999, 0, 0);
    step(0, 1, 32'd2, 32'd2, 0, 0);
    step(1, 1, 32'd4, 32'd4, 0, 0);
    step(0, 1, 32'd8, 32'd8, 0, 0);
    step(0, 0, 32'd0, 32'd0, 0, 0);
    step(1, 0, 32'd0, 32'd0, 0, 0);
    idle(1, 2);

    // Random traffic, mixed controls (R3 R4 R5 R6 R7 R10)
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      step(0, $urandom_range(3) != 0, $urandom, $urandom,
           $urandom_range(15) == 0, $urandom_range(1));
    end
    cur_req = "R4";
    for (int i = 0; i < 400; i++) begin
      step(1, $urandom_range(3) != 0, $urandom, $urandom,
           $urandom_range(15) == 0, $urandom_range(1));
    end
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(1), $urandom_range(1), $urandom, $urandom,
           $urandom_range(7) == 0, $urandom_range(1));
    end

    // R1: reset in the middle of activity
    cur_req = "R1";
    step(1, 1, 32'h1234_5678, 32'h8765_4321, 0, 1);
    @(negedge clk); #1 rst_n = 0;
    step(0, 1, 32'd5, 32'd5, 0, 1);
    step(0, 1, 32'd5, 32'd5, 0, 1);
    step(0, 0, 32'd0, 32'd0, 0, 0);
    @(negedge clk); #1 rst_n = 1;
    idle(0, 3);
    step(0, 1, 32'd21, 32'd2, 0, 1);
    idle(0, 2);

    finish_run();
  end

endmodule